// File: doc/BRIEF.md
# Recently Activated Row Latency Cache

Each time a row is opened, its cells are brought back to full charge, and for a short time after that the same row can be opened again with shorter activation and restore times. This block keeps a small fully associative table of the bank and row pairs that were activated most recently. A bank timing unit uses it in two ways. It reports every activation on the ACT port. Before it issues an activation, it presents a bank and row on the lookup port. On a hit the block returns the reduced row-to-column delay and the reduced minimum row-active time. On a miss it returns the nominal values.

Each slot runs its own small state machine with the states `SLOT_EMPTY`, `SLOT_FRESH` and `SLOT_STALE`. The transitions are:
- `SLOT_EMPTY` or `SLOT_STALE` goes to `SLOT_FRESH` on load.
- `SLOT_FRESH` goes back to `SLOT_FRESH` on reload, which clears its age.
- `SLOT_FRESH` goes to `SLOT_STALE` on expire, once its age is no longer below the window.
- Any state goes to `SLOT_EMPTY` on flush.

A slot's age advances only on cycles where the `tick` input is high. The window is a programmable count of ticks. With ticks of 1 µs it is typically set near 1000, because a row is trusted to stay charged for about a millisecond. That is well inside the 64 ms refresh interval.

Top module: `row_charge_cache`

## Requirements
- R1: After reset every slot is `SLOT_EMPTY`, every lookup misses (`lk_hit`=0), and `trcd_out`/`tras_out` equal `trcd_nom`/`tras_nom`.
- R2: An ACT (`act_valid`=1 at a rising edge) records {bank,row}. From the next cycle a lookup of that bank and row hits, provided `window` is not 0.
- R3: A lookup that hits drives `trcd_fast`/`tras_fast`. A lookup that misses drives `trcd_nom`/`tras_nom`. The match needs both the bank and the row to be equal.
- R4: An entry stops hitting once `window` ticks have been counted since its last ACT. After `window`-1 ticks it still hits.
- R5: Age advances only on cycles with `tick`=1. Without ticks, an entry keeps hitting however many cycles pass.
- R6: An ACT to a bank and row already held in the table, whether fresh or stale, reuses that slot and clears its age. No second copy is made.
- R7: A new ACT takes an empty or expired slot before it evicts any live entry. Among such slots the lowest index is taken.
- R8: When all slots are live, a new ACT replaces the slot with the largest age. On equal ages the lowest index is replaced.
- R9: `flush`=1 empties every slot at that edge, and it overrides an ACT in the same cycle.
- R10: Lookup is combinational on the current table. An ACT is not visible to a lookup in the same cycle, only from the next cycle.
- R11: With `window`=0 no lookup ever hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_valid | input | 1 | An activation is being reported |
| act_bank | input | BANK_W | Bank of the reported activation |
| act_row | input | ROW_W | Row of the reported activation |
| tick | input | 1 | Time base pulse that ages fresh entries |
| flush | input | 1 | Invalidate every entry |
| window | input | AGE_W | Freshness window in ticks |
| lk_bank | input | BANK_W | Lookup bank |
| lk_row | input | ROW_W | Lookup row |
| trcd_nom | input | TIM_W | Nominal row-to-column delay |
| tras_nom | input | TIM_W | Nominal row-active time |
| trcd_fast | input | TIM_W | Reduced row-to-column delay |
| tras_fast | input | TIM_W | Reduced row-active time |
| lk_hit | output | 1 | Lookup matched a fresh entry |
| trcd_out | output | TIM_W | Row-to-column delay to apply |
| tras_out | output | TIM_W | Row-active time to apply |

## Verification
The outputs are combinational on the table, so a lookup result is due in the same cycle the lookup is presented. A change caused by an ACT, a tick or a flush is due one cycle later, after the single register stage of each slot. The bench changes every input at the falling edge and lets the rising edge capture it. It then presents the lookup at the next falling edge and samples `lk_hit` and the timings one time step later. The same-cycle case for R10 is read before the capturing edge. The expiry boundary for R4 is probed at exactly `window`-1 and `window` ticks.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
    typedef enum logic [1:0] {
        SLOT_EMPTY = 2'd0,
        SLOT_FRESH = 2'd1,
        SLOT_STALE = 2'd2
    } slot_state_e;
endpackage

// File: rtl/rcc_slot.sv
module rcc_slot
    import rcc_pkg::*;
#(
    parameter int KEY_W = 17,
    parameter int AGE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             load,
    input  logic [KEY_W-1:0] key_in,
    input  logic             tick,
    input  logic [AGE_W-1:0] window,
    output logic [KEY_W-1:0] key,
    output logic [AGE_W-1:0] age,
    output slot_state_e      state,
    output logic             live
);
    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    slot_state_e state_nxt;

    assign live = (state == SLOT_FRESH) && (age < window);

    always_comb begin
        state_nxt = state;
        if (flush) begin
            state_nxt = SLOT_EMPTY;
        end else if (load) begin
            state_nxt = SLOT_FRESH;
        end else begin
            unique case (state)
                SLOT_EMPTY: state_nxt = SLOT_EMPTY;
                SLOT_FRESH: if (!live) state_nxt = SLOT_STALE;
                SLOT_STALE: state_nxt = SLOT_STALE;
                default:    state_nxt = SLOT_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SLOT_EMPTY;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age <= '0;
            key <= '0;
        end else if (load && !flush) begin
            age <= '0;
            key <= key_in;
        end else if (tick && state == SLOT_FRESH && age != AGE_MAX) begin
            age <= age + 1'b1;
        end
    end
endmodule

// File: rtl/rcc_victim.sv
module rcc_victim #(
    parameter int ENTRIES = 8,
    parameter int AGE_W   = 12,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]            reusable,
    input  logic [ENTRIES-1:0][AGE_W-1:0] ages,
    output logic [IDX_W-1:0]              victim
);
    logic             free_found;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] old_idx;
    logic [AGE_W-1:0] old_age;

    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (reusable[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
        old_idx = '0;
        old_age = ages[0];
        for (int i = 1; i < ENTRIES; i++) begin
            if (ages[i] > old_age) begin
                old_age = ages[i];
                old_idx = IDX_W'(i);
            end
        end
        victim = free_found ? free_idx : old_idx;
    end
endmodule

// File: rtl/row_charge_cache.sv
module row_charge_cache
    import rcc_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int BANK_W  = 3,
    parameter int ROW_W   = 14,
    parameter int AGE_W   = 12,
    parameter int TIM_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_valid,
    input  logic [BANK_W-1:0] act_bank,
    input  logic [ROW_W-1:0]  act_row,
    input  logic              tick,
    input  logic              flush,
    input  logic [AGE_W-1:0]  window,
    input  logic [BANK_W-1:0] lk_bank,
    input  logic [ROW_W-1:0]  lk_row,
    input  logic [TIM_W-1:0]  trcd_nom,
    input  logic [TIM_W-1:0]  tras_nom,
    input  logic [TIM_W-1:0]  trcd_fast,
    input  logic [TIM_W-1:0]  tras_fast,
    output logic              lk_hit,
    output logic [TIM_W-1:0]  trcd_out,
    output logic [TIM_W-1:0]  tras_out
);
    localparam int KEY_W = BANK_W + ROW_W;
    localparam int IDX_W = $clog2(ENTRIES);

    logic [KEY_W-1:0] act_key;
    logic [KEY_W-1:0] lk_key;
    logic [ENTRIES-1:0] ent_used;
    logic [ENTRIES-1:0] ent_live;
    logic [ENTRIES-1:0] act_match;
    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] load;
    logic [ENTRIES-1:0][AGE_W-1:0] ages;
    logic [IDX_W-1:0] victim;
    logic any_act_match;

    assign act_key       = {act_bank, act_row};
    assign lk_key        = {lk_bank, lk_row};
    assign any_act_match = |act_match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        logic [KEY_W-1:0] key;
        slot_state_e      state;

        rcc_slot #(.KEY_W(KEY_W), .AGE_W(AGE_W)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .flush  (flush),
            .load   (load[g]),
            .key_in (act_key),
            .tick   (tick),
            .window (window),
            .key    (key),
            .age    (ages[g]),
            .state  (state),
            .live   (ent_live[g])
        );

        assign ent_used[g]  = (state != SLOT_EMPTY);
        assign act_match[g] = ent_used[g] && (key == act_key);
        assign lk_match[g]  = ent_live[g] && (key == lk_key);
        assign load[g]      = act_valid &&
                              (any_act_match ? act_match[g] : (victim == IDX_W'(g)));
    end

    rcc_victim #(.ENTRIES(ENTRIES), .AGE_W(AGE_W)) u_victim (
        .reusable (~ent_live),
        .ages     (ages),
        .victim   (victim)
    );

    always_comb begin
        lk_hit   = |lk_match;
        trcd_out = lk_hit ? trcd_fast : trcd_nom;
        tras_out = lk_hit ? tras_fast : tras_nom;
    end
endmodule

// File: rtl/rcc_checker.sv
module rcc_checker #(
    parameter int ENTRIES = 8,
    parameter int BANK_W  = 3,
    parameter int ROW_W   = 14,
    parameter int AGE_W   = 12,
    parameter int TIM_W   = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              act_valid,
    input logic [BANK_W-1:0] act_bank,
    input logic [ROW_W-1:0]  act_row,
    input logic              flush,
    input logic [AGE_W-1:0]  window,
    input logic [BANK_W-1:0] lk_bank,
    input logic [ROW_W-1:0]  lk_row,
    input logic [TIM_W-1:0]  trcd_nom,
    input logic [TIM_W-1:0]  tras_nom,
    input logic [TIM_W-1:0]  trcd_fast,
    input logic [TIM_W-1:0]  tras_fast,
    input logic              lk_hit,
    input logic [TIM_W-1:0]  trcd_out,
    input logic [TIM_W-1:0]  tras_out,
    input logic [ENTRIES-1:0] ent_used,
    input logic [ENTRIES-1:0] act_match
);
    a_r2_act_then_hit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(act_valid && !flush) && window != '0 &&
         lk_bank == $past(act_bank) && lk_row == $past(act_row)) |-> lk_hit);

    a_r3_fast_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (trcd_out == trcd_fast && tras_out == tras_fast));

    a_r3_nom_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (trcd_out == trcd_nom && tras_out == tras_nom));

    a_r6_no_duplicate: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(act_match));

    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(flush)) |-> (ent_used == '0 && !lk_hit));

    a_r11_zero_window: assert property (@(posedge clk) disable iff (!rst_n)
        (window == '0) |-> !lk_hit);
endmodule

bind row_charge_cache rcc_checker #(
    .ENTRIES(ENTRIES), .BANK_W(BANK_W), .ROW_W(ROW_W), .AGE_W(AGE_W), .TIM_W(TIM_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .act_valid (act_valid),
    .act_bank  (act_bank),
    .act_row   (act_row),
    .flush     (flush),
    .window    (window),
    .lk_bank   (lk_bank),
    .lk_row    (lk_row),
    .trcd_nom  (trcd_nom),
    .tras_nom  (tras_nom),
    .trcd_fast (trcd_fast),
    .tras_fast (tras_fast),
    .lk_hit    (lk_hit),
    .trcd_out  (trcd_out),
    .tras_out  (tras_out),
    .ent_used  (ent_used),
    .act_match (act_match)
);

// File: tb/tb_row_charge_cache.sv
`timescale 1ns/1ps
module tb_row_charge_cache;
    localparam int BANK_W = 3;
    localparam int ROW_W  = 14;
    localparam int AGE_W  = 12;
    localparam int TIM_W  = 6;
    localparam logic [TIM_W-1:0] RCD_N = 6'd14, RAS_N = 6'd32;
    localparam logic [TIM_W-1:0] RCD_F = 6'd9,  RAS_F = 6'd22;

    // vector: [19:18] kind (0 act, 1 tick, 2 lookup, 3 flush), [17:15] bank, [14:1] row, [0] expected hit
    localparam int NV = 20;
    localparam logic [19:0] VEC [NV] = '{
        {2'd0, 3'd1, 14'd100, 1'b0},
        {2'd2, 3'd1, 14'd100, 1'b1},
        {2'd2, 3'd2, 14'd100, 1'b0},
        {2'd2, 3'd1, 14'd101, 1'b0},
        {2'd1, 3'd0, 14'd0,   1'b0},
        {2'd1, 3'd0, 14'd0,   1'b0},
        {2'd2, 3'd1, 14'd100, 1'b1},
        {2'd1, 3'd0, 14'd0,   1'b0},
        {2'd2, 3'd1, 14'd100, 1'b0},
        {2'd0, 3'd1, 14'd100, 1'b0},
        {2'd2, 3'd1, 14'd100, 1'b1},
        {2'd1, 3'd0, 14'd0,   1'b0},
        {2'd1, 3'd0, 14'd0,   1'b0},
        {2'd0, 3'd1, 14'd100, 1'b0},
        {2'd1, 3'd0, 14'd0,   1'b0},
        {2'd1, 3'd0, 14'd0,   1'b0},
        {2'd2, 3'd1, 14'd100, 1'b1},
        {2'd1, 3'd0, 14'd0,   1'b0},
        {2'd2, 3'd1, 14'd100, 1'b0},
        {2'd3, 3'd0, 14'd0,   1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic act_valid = 1'b0;
    logic [BANK_W-1:0] act_bank = '0;
    logic [ROW_W-1:0]  act_row = '0;
    logic tick = 1'b0;
    logic flush = 1'b0;
    logic [AGE_W-1:0] window = 12'd3;
    logic [BANK_W-1:0] lk_bank = '0;
    logic [ROW_W-1:0]  lk_row = '0;
    logic lk_hit;
    logic [TIM_W-1:0] trcd_out, tras_out;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    row_charge_cache dut (
        .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_bank(act_bank),
        .act_row(act_row), .tick(tick), .flush(flush), .window(window),
        .lk_bank(lk_bank), .lk_row(lk_row), .trcd_nom(RCD_N), .tras_nom(RAS_N),
        .trcd_fast(RCD_F), .tras_fast(RAS_F), .lk_hit(lk_hit),
        .trcd_out(trcd_out), .tras_out(tras_out)
    );

    task automatic look(input logic [BANK_W-1:0] b, input logic [ROW_W-1:0] r,
                        input logic exp, input string req);
        logic [TIM_W-1:0] er, ea;
        lk_bank = b;
        lk_row  = r;
        #1;
        er = exp ? RCD_F : RCD_N;
        ea = exp ? RAS_F : RAS_N;
        checks++;
        if (lk_hit !== exp || trcd_out !== er || tras_out !== ea) begin
            failures++;
            $display("FAIL %s bank=%0d row=%0d hit=%0b/%0b trcd=%0d/%0d tras=%0d/%0d",
                     req, b, r, lk_hit, exp, trcd_out, er, tras_out, ea);
        end
    endtask

    task automatic act(input logic [BANK_W-1:0] b, input logic [ROW_W-1:0] r);
        @(negedge clk);
        act_valid = 1'b1; act_bank = b; act_row = r;
        @(negedge clk);
        act_valid = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        look(3'd1, 14'd100, 1'b0, "R1");
        rst_n = 1'b1;
        look(3'd0, 14'd0, 1'b0, "R1");

        // table walk: R2, R3, R4, R6 with window 3
        for (int v = 0; v < NV; v++) begin
            unique case (VEC[v][19:18])
                2'd0: act(VEC[v][17:15], VEC[v][14:1]);
                2'd1: ticks(1);
                2'd2: look(VEC[v][17:15], VEC[v][14:1], VEC[v][0], "R2/R3/R4/R6");
                2'd3: do_flush();
                default: ;
            endcase
        end
        look(3'd1, 14'd100, 1'b0, "R9");

        // R5: no ticks, no expiry
        act(3'd4, 14'd9);
        repeat (40) @(negedge clk);
        look(3'd4, 14'd9, 1'b1, "R5");

        // R8: all live, oldest replaced
        do_flush();
        window = 12'd200;
        for (int i = 0; i < 8; i++) begin
            act(3'd0, ROW_W'(i));
            ticks(1);
        end
        act(3'd0, 14'd50);
        look(3'd0, 14'd0, 1'b0, "R8");
        look(3'd0, 14'd1, 1'b1, "R8");
        look(3'd0, 14'd7, 1'b1, "R8");
        look(3'd0, 14'd50, 1'b1, "R8");

        // R7: expired slot reused before eviction
        do_flush();
        window = 12'd3;
        act(3'd0, 14'd0);
        ticks(3);
        for (int i = 1; i < 8; i++) act(3'd0, ROW_W'(i));
        act(3'd0, 14'd20);
        look(3'd0, 14'd20, 1'b1, "R7");
        for (int i = 1; i < 8; i++) look(3'd0, ROW_W'(i), 1'b1, "R7");

        // R9: flush overrides a simultaneous ACT
        @(negedge clk);
        flush = 1'b1; act_valid = 1'b1; act_bank = 3'd5; act_row = 14'd33;
        @(negedge clk);
        flush = 1'b0; act_valid = 1'b0;
        look(3'd5, 14'd33, 1'b0, "R9");
        look(3'd0, 14'd3, 1'b0, "R9");

        // R10: same-cycle ACT not visible until next cycle
        @(negedge clk);
        act_valid = 1'b1; act_bank = 3'd2; act_row = 14'd77;
        look(3'd2, 14'd77, 1'b0, "R10");
        @(negedge clk);
        act_valid = 1'b0;
        look(3'd2, 14'd77, 1'b1, "R10");

        // R11: zero window never hits
        window = 12'd0;
        act(3'd6, 14'd6);
        look(3'd6, 14'd6, 1'b0, "R11");
        look(3'd2, 14'd77, 1'b0, "R11");

        finish_run();
    end
endmodule